// File: doc/BRIEF.md
# Instruction-fetch line buffer controller

This block sits beside a direct-mapped instruction cache with 16-byte lines and 64 sets. It manages a single line-sized staging buffer. When a fetch misses both the buffer and the cache array, the block requests the line from the external bus as a four-longword wrapping burst. The burst starts with the longword that was asked for, so the processor can restart as soon as that beat arrives. The other longwords then fill the buffer, and later fetches can hit in it word by word, even before the burst has finished.

The buffer remembers its line address, the longwords that have arrived, and whether its contents were fetched as cacheable. A complete cacheable line is copied into the cache array only when the next miss happens. A one-bit recency flag records whether the buffer or the array entry at the same index was touched more recently. Four controls choose the behaviour: cache enable, buffer enable, burst permission, and the per-fetch cacheable attribute. Noncacheable lines may be staged in the buffer and hit there, but they never reach the array.

Top module: `ifill_buf_ctrl`

## Requirements
- R1: After reset, `bus_req`, `rsp_valid`, `aw_en` and `buf_mru` are low, and the buffer holds no valid longword, so the first fetch goes to the bus.
- R2: A burst miss drives `bus_addr` equal to the fetch address with bits 1:0 cleared and `bus_burst` high. It holds `bus_req` until `bus_ack`. The beats return longword offsets (address bits 3:2) in the order c, c+1, c+2, c+3 modulo 4, where c is the requested offset.
- R3: On a miss, `rsp_valid` rises in the cycle the first bus beat arrives, with `rsp_data` equal to `bus_rdata` and both hit flags low.
- R4: A fetch whose line address (bits 31:4) matches the buffer and whose longword has arrived gets `rsp_valid` with `rsp_buf_hit` high and the stored data in the same cycle. This also applies during a fill once the first beat has been delivered. A buffered fetch to a longword that has not yet arrived waits without a new bus request.
- R5: `buf_mru` is set by any miss that starts a burst into the buffer, and it is high while that burst is requested.
- R6: A fetch served by the cache array (`rsp_arr_hit`) at the buffer's index (bits 9:4) clears `buf_mru`. An array hit at another index leaves it unchanged.
- R7: On a miss, `aw_en` pulses for one cycle only if the buffer is complete, was filled as cacheable, has not yet been written, and cache enable is set. `aw_index` is bits 9:4, `aw_tag` is bits 31:10, and `aw_data[32k+31:32k]` is longword k. The buffer keeps hitting afterwards, and no second write of the same line occurs.
- R8: With buffer enable set, a noncacheable burst or one taken with the cache disabled is staged in the buffer and hits later, but is never written to the array.
- R9: A burst into the buffer happens exactly when burst permission is set and either the buffer is enabled or the fetch is cacheable with the cache enabled. Any other miss is a single longword transfer (`bus_burst` low) that leaves the buffer unchanged.
- R10: With burst permission clear, every miss is a single transfer, and later fetches to that line miss again.
- R11: `arr_hit` answers a fetch (`rsp_arr_hit` high, no bus request) only when cache enable is set, the fetch is cacheable, and the buffer does not hit. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cache_en | input | 1 | Cache array enable |
| cfg_buf_en | input | 1 | Line buffer enable |
| cfg_burst_en | input | 1 | Line-sized bursts permitted |
| req_valid | input | 1 | Fetch request, held until `rsp_valid` |
| req_addr | input | 32 | Fetch byte address |
| req_cacheable | input | 1 | Fetch is cacheable |
| arr_hit | input | 1 | Cache array tag match for `req_addr` |
| rsp_valid | output | 1 | Fetch completes this cycle |
| rsp_data | output | 32 | Longword from buffer or bus |
| rsp_buf_hit | output | 1 | Served by the line buffer |
| rsp_arr_hit | output | 1 | Served by the cache array |
| buf_mru | output | 1 | Buffer is more recent than the array entry at its index |
| bus_req | output | 1 | Bus transfer request |
| bus_burst | output | 1 | Request is a four-beat wrapping burst |
| bus_addr | output | 32 | Address of the first longword |
| bus_ack | input | 1 | Bus accepted the request |
| bus_rvalid | input | 1 | Read beat valid |
| bus_rdata | input | 32 | Read beat data |
| aw_en | output | 1 | Array line write strobe |
| aw_index | output | 6 | Array set index |
| aw_tag | output | 22 | Array tag |
| aw_data | output | 128 | Line data, longword k at bits 32k+31:32k |

## Verification
A longword stored in the wrong slot does not show at once. It appears as wrong `rsp_data` on a later buffer hit, or as a misplaced word in `aw_data` at the next miss, so the bench reads back every offset and every committed word. A wrong valid bit or line address turns an expected hit into an extra bus request, or a miss into a hit, within the next fetch. A wrong cacheable or written-back flag only surfaces one miss later, as a missing, extra or repeated `aw_en` pulse. A stuck recency flag is seen directly on `buf_mru` after the fetch that should have changed it.

// File: rtl/ifill_pkg.sv
package ifill_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } ifill_state_e;

   typedef struct packed {
      logic use_buf;    // buffer may answer this fetch
      logic use_arr;    // cache array may answer this fetch
      logic fill;       // a miss bursts into the buffer
      logic fill_cach;  // that fill is eligible for array commit
   } ifill_mode_t;

endpackage

// File: rtl/ifill_mode_dec.sv
module ifill_mode_dec
   import ifill_pkg::*;
#(
   parameter bit NC_FILL = 1'b1
) (
   input  logic        cache_en,
   input  logic        buf_en,
   input  logic        burst_en,
   input  logic        cacheable,
   output ifill_mode_t mode_o
);

   logic arr_ok;
   logic stage_ok;

   assign arr_ok = cache_en & cacheable;

   generate
      if (NC_FILL) begin : g_nc_stage
         assign stage_ok = arr_ok | buf_en;
      end else begin : g_cache_only
         logic unused_buf_en;
         assign unused_buf_en = buf_en;
         assign stage_ok      = arr_ok;
      end
   endgenerate

   always_comb begin
      mode_o.use_buf   = stage_ok;
      mode_o.use_arr   = arr_ok;
      mode_o.fill      = stage_ok & burst_en;
      mode_o.fill_cach = arr_ok;
   end

endmodule

// File: rtl/ifill_wrap_seq.sv
module ifill_wrap_seq #(
   parameter int OFF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OFF_W-1:0] crit,
   input  logic             burst,
   input  logic             beat,
   output logic [OFF_W-1:0] slot_o,
   output logic             last_o
);

   logic [OFF_W-1:0] crit_q;
   logic [OFF_W-1:0] cnt_q;
   logic             burst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crit_q  <= '0;
         cnt_q   <= '0;
         burst_q <= 1'b0;
      end else if (start) begin
         crit_q  <= crit;
         cnt_q   <= '0;
         burst_q <= burst;
      end else if (beat) begin
         cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      end
   end

   // offset arithmetic wraps naturally at the line size
   assign slot_o = crit_q + cnt_q;
   assign last_o = !burst_q || (&cnt_q);

endmodule

// File: rtl/ifill_line_store.sv
module ifill_line_store #(
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   parameter int KEY_W  = 28,
   parameter int SLOT_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic [KEY_W-1:0]        key_in,
   input  logic                    pend_in,
   input  logic                    done,
   input  logic                    wr_en,
   input  logic [SLOT_W-1:0]       wr_slot,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [SLOT_W-1:0]       rd_slot,
   output logic [KEY_W-1:0]        key_o,
   output logic [WORDS-1:0]        valid_o,
   output logic                    pend_o,
   output logic [DATA_W-1:0]       rd_data,
   output logic [WORDS*DATA_W-1:0] line_o
);

   logic [DATA_W-1:0] word_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_o  <= '0;
         pend_o <= 1'b0;
      end else if (clear) begin
         key_o  <= key_in;
         pend_o <= pend_in;
      end else if (done) begin
         pend_o <= 1'b0;
      end
   end

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_o[w] <= 1'b0;
            end else if (clear) begin
               valid_o[w] <= 1'b0;
            end else if (wr_en && wr_slot == SLOT_W'(w)) begin
               valid_o[w] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (wr_en && wr_slot == SLOT_W'(w)) begin
               word_q[w] <= wr_data;
            end
         end

         assign line_o[w*DATA_W +: DATA_W] = word_q[w];
      end
   endgenerate

   assign rd_data = word_q[rd_slot];

endmodule

// File: rtl/ifill_buf_ctrl.sv
module ifill_buf_ctrl
   import ifill_pkg::*;
#(
   parameter int  ADDR_W     = 32,
   parameter int  DATA_W     = 32,
   parameter int  LINE_WORDS = 4,
   parameter int  SETS       = 64,
   parameter bit  NC_FILL    = 1'b1,
   localparam int BYTE_W     = $clog2(DATA_W / 8),
   localparam int OFF_W      = $clog2(LINE_WORDS),
   localparam int IDX_W      = $clog2(SETS),
   localparam int LOW_W      = BYTE_W + OFF_W,
   localparam int KEY_W      = ADDR_W - LOW_W,
   localparam int TAG_W      = KEY_W - IDX_W,
   localparam int LINE_W     = DATA_W * LINE_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cache_en,
   input  logic              cfg_buf_en,
   input  logic              cfg_burst_en,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_cacheable,
   input  logic              arr_hit,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_buf_hit,
   output logic              rsp_arr_hit,
   output logic              buf_mru,
   output logic              bus_req,
   output logic              bus_burst,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_ack,
   input  logic              bus_rvalid,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              aw_en,
   output logic [IDX_W-1:0]  aw_index,
   output logic [TAG_W-1:0]  aw_tag,
   output logic [LINE_W-1:0] aw_data
);

   // ---------------- elaboration checks ----------------
   if (DATA_W < 16 || (1 << BYTE_W) * 8 != DATA_W) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 16");
   end
   if (LINE_WORDS < 2 || (1 << OFF_W) != LINE_WORDS) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the chosen geometry");
   end

   // ---------------- address fields ----------------
   logic [KEY_W-1:0]  req_key;
   logic [IDX_W-1:0]  req_idx;
   logic [OFF_W-1:0]  req_off;
   logic [BYTE_W-1:0] unused_byte;

   assign req_key     = req_addr[ADDR_W-1:LOW_W];
   assign req_idx     = req_key[IDX_W-1:0];
   assign req_off     = req_addr[BYTE_W +: OFF_W];
   assign unused_byte = req_addr[BYTE_W-1:0];

   // ---------------- mode decode ----------------
   ifill_mode_t mode;

   ifill_mode_dec #(.NC_FILL(NC_FILL)) u_mode (
      .cache_en  (cfg_cache_en),
      .buf_en    (cfg_buf_en),
      .burst_en  (cfg_burst_en),
      .cacheable (req_cacheable),
      .mode_o    (mode)
   );

   // ---------------- state ----------------
   ifill_state_e     st_q;
   logic [KEY_W-1:0] miss_key_q;
   logic [OFF_W-1:0] miss_off_q;
   logic             miss_fill_q;
   logic             crit_done_q;
   logic             mru_q;

   // buffer and sequencer wires
   logic [KEY_W-1:0]      buf_key;
   logic [LINE_WORDS-1:0] buf_valid;
   logic                  buf_pend;
   logic [DATA_W-1:0]     buf_rd;
   logic [LINE_W-1:0]     buf_line;
   logic [OFF_W-1:0]      seq_slot;
   logic                  seq_last;

   // ---------------- decisions ----------------
   logic serve, buf_match, arr_ok, hit_buf, hit_arr;
   logic miss_go, beat, crit_beat, commit, same_idx;

   assign serve     = req_valid && (st_q == ST_IDLE || (st_q == ST_DATA && crit_done_q));
   assign buf_match = mode.use_buf && (buf_key == req_key) && buf_valid[req_off];
   assign arr_ok    = mode.use_arr && arr_hit && !buf_match;
   assign hit_buf   = serve && buf_match;
   assign hit_arr   = serve && arr_ok;
   assign miss_go   = req_valid && (st_q == ST_IDLE) && !buf_match && !arr_ok;
   assign beat      = (st_q == ST_DATA) && bus_rvalid;
   assign crit_beat = beat && !crit_done_q;
   assign commit    = miss_go && buf_pend && (&buf_valid) && cfg_cache_en;
   assign same_idx  = (req_idx == buf_key[IDX_W-1:0]);

   // ---------------- line buffer ----------------
   ifill_line_store #(
      .WORDS  (LINE_WORDS),
      .DATA_W (DATA_W),
      .KEY_W  (KEY_W),
      .SLOT_W (OFF_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (miss_go && mode.fill),
      .key_in  (req_key),
      .pend_in (mode.fill_cach),
      .done    (commit),
      .wr_en   (beat && miss_fill_q),
      .wr_slot (seq_slot),
      .wr_data (bus_rdata),
      .rd_slot (req_off),
      .key_o   (buf_key),
      .valid_o (buf_valid),
      .pend_o  (buf_pend),
      .rd_data (buf_rd),
      .line_o  (buf_line)
   );

   // ---------------- wrap sequencer ----------------
   ifill_wrap_seq #(.OFF_W(OFF_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (miss_go),
      .crit   (req_off),
      .burst  (mode.fill),
      .beat   (beat),
      .slot_o (seq_slot),
      .last_o (seq_last)
   );

   // ---------------- control FSM ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         miss_key_q  <= '0;
         miss_off_q  <= '0;
         miss_fill_q <= 1'b0;
         crit_done_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (miss_go) begin
                  st_q        <= ST_ADDR;
                  miss_key_q  <= req_key;
                  miss_off_q  <= req_off;
                  miss_fill_q <= mode.fill;
                  crit_done_q <= 1'b0;
               end
            end
            ST_ADDR: begin
               if (bus_ack) begin
                  st_q <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (beat) begin
                  crit_done_q <= 1'b1;
                  if (seq_last) begin
                     st_q <= ST_IDLE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------- recency flag ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mru_q <= 1'b0;
      end else if (miss_go && mode.fill) begin
         mru_q <= 1'b1;
      end else if (hit_arr && same_idx) begin
         mru_q <= 1'b0;
      end
   end

   // ---------------- outputs ----------------
   assign rsp_valid   = hit_buf || hit_arr || crit_beat;
   assign rsp_data    = crit_beat ? bus_rdata : buf_rd;
   assign rsp_buf_hit = hit_buf;
   assign rsp_arr_hit = hit_arr;
   assign buf_mru     = mru_q;

   assign bus_req   = (st_q == ST_ADDR);
   assign bus_burst = miss_fill_q;
   assign bus_addr  = {miss_key_q, miss_off_q, {BYTE_W{1'b0}}};

   assign aw_en    = commit;
   assign aw_index = buf_key[IDX_W-1:0];
   assign aw_tag   = buf_key[KEY_W-1:IDX_W];
   assign aw_data  = buf_line;

endmodule

// File: rtl/ifill_buf_ctrl_chk.sv
module ifill_buf_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_cache_en,
   input logic cfg_burst_en,
   input logic req_valid,
   input logic rsp_valid,
   input logic rsp_buf_hit,
   input logic rsp_arr_hit,
   input logic buf_mru,
   input logic bus_req,
   input logic bus_burst,
   input logic bus_ack,
   input logic bus_rvalid,
   input logic aw_en
);

   // R11
   src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_buf_hit || rsp_arr_hit) |-> (rsp_valid && $onehot0({rsp_buf_hit, rsp_arr_hit})));

   // R3
   crit_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_buf_hit && !rsp_arr_hit) |-> bus_rvalid);

   // R2
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> bus_req);

   // R5
   mru_on_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_burst) |-> buf_mru);

   // R7
   commit_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aw_en |-> (cfg_cache_en && req_valid && !rsp_valid));

   // R7
   commit_then_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aw_en |=> bus_req);

   // R10
   burst_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_burst) |-> cfg_burst_en);

endmodule

bind ifill_buf_ctrl ifill_buf_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_cache_en (cfg_cache_en),
   .cfg_burst_en (cfg_burst_en),
   .req_valid    (req_valid),
   .rsp_valid    (rsp_valid),
   .rsp_buf_hit  (rsp_buf_hit),
   .rsp_arr_hit  (rsp_arr_hit),
   .buf_mru      (buf_mru),
   .bus_req      (bus_req),
   .bus_burst    (bus_burst),
   .bus_ack      (bus_ack),
   .bus_rvalid   (bus_rvalid),
   .aw_en        (aw_en)
);

// File: tb/ifill_buf_ctrl_tb.sv
`timescale 1ns/1ps
module ifill_buf_ctrl_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_cache_en = 1'b1, cfg_buf_en = 1'b1, cfg_burst_en = 1'b1;
   logic         req_valid = 1'b0;
   logic [31:0]  req_addr = '0;
   logic         req_cacheable = 1'b0;
   logic         arr_hit = 1'b0;
   logic         rsp_valid, rsp_buf_hit, rsp_arr_hit, buf_mru;
   logic [31:0]  rsp_data;
   logic         bus_req, bus_burst;
   logic [31:0]  bus_addr;
   logic         bus_ack = 1'b0, bus_rvalid = 1'b0;
   logic [31:0]  bus_rdata = '0;
   logic         aw_en;
   logic [5:0]   aw_index;
   logic [21:0]  aw_tag;
   logic [127:0] aw_data;

   always #5 clk = ~clk;

   ifill_buf_ctrl u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_cache_en(cfg_cache_en), .cfg_buf_en(cfg_buf_en), .cfg_burst_en(cfg_burst_en),
      .req_valid(req_valid), .req_addr(req_addr), .req_cacheable(req_cacheable), .arr_hit(arr_hit),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_buf_hit(rsp_buf_hit), .rsp_arr_hit(rsp_arr_hit),
      .buf_mru(buf_mru),
      .bus_req(bus_req), .bus_burst(bus_burst), .bus_addr(bus_addr),
      .bus_ack(bus_ack), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .aw_en(aw_en), .aw_index(aw_index), .aw_tag(aw_tag), .aw_data(aw_data)
   );

   int           n_run = 0, n_fail = 0;
   int           bus_cnt = 0, aw_cnt = 0;
   logic [31:0]  b_addr = '0;
   logic         b_burst = 1'b0;
   logic [5:0]   aw_idx_s = '0;
   logic [21:0]  aw_tag_s = '0;
   logic [127:0] aw_data_s = '0;

   function automatic logic [31:0] pat(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
   endfunction

   task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
      end
   endtask

   // bus model: wrapping beats with a one-cycle gap
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && bus_req) begin
            b_addr  = bus_addr;
            b_burst = bus_burst;
            bus_cnt++;
            bus_ack = 1'b1;
            @(negedge clk);
            bus_ack = 1'b0;
            for (int k = 0; k < (b_burst ? 4 : 1); k++) begin
               logic [1:0] off;
               @(negedge clk);
               off        = b_addr[3:2] + 2'(k);
               bus_rvalid = 1'b1;
               bus_rdata  = pat({b_addr[31:4], off, 2'b00});
               @(negedge clk);
               bus_rvalid = 1'b0;
            end
         end
      end
   end

   // array write monitor
   always begin
      @(negedge clk);
      #1;
      if (rst_n && aw_en) begin
         aw_cnt++;
         aw_idx_s  = aw_index;
         aw_tag_s  = aw_tag;
         aw_data_s = aw_data;
      end
   end

   // one fetch; called at a falling edge
   task automatic fetch(input logic [31:0] a, input logic c, input logic ah,
                        output int src, output logic [31:0] d);
      int n;
      n = 0;
      src = -1;
      d = '0;
      req_valid = 1'b1; req_addr = a; req_cacheable = c; arr_hit = ah;
      forever begin
         #1;
         if (rsp_valid) begin
            src = rsp_buf_hit ? 1 : (rsp_arr_hit ? 2 : 0);
            d   = rsp_data;
            break;
         end
         @(negedge clk);
         n++;
         if (n > 500) begin
            n_fail++;
            $display("FAIL fetch timeout at %0h", a);
            break;
         end
      end
      @(negedge clk);
      req_valid = 1'b0; arr_hit = 1'b0;
   endtask

   task automatic do_reset();
      repeat (14) @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic check_line(input string r, input logic [31:0] base);
      for (int k = 0; k < 4; k++) begin
         chk(r, "aw_data word", aw_data_s[k*32 +: 32], pat({base[31:4], 2'(k), 2'b00}));
      end
   endtask

   initial begin
      int          src, bc, ac;
      logic [31:0] d, A, B;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "bus_req", bus_req, 0);
      chk("R1", "rsp_valid", rsp_valid, 0);
      chk("R1", "aw_en", aw_en, 0);
      chk("R1", "buf_mru", buf_mru, 0);
      @(negedge clk);

      // ---- directed: cacheable burst, wrap order, hits during fill ----
      A = 32'h0000_1238;
      fetch(A, 1, 0, src, d);
      chk("R3", "miss src", src, 0);
      chk("R3", "critical data", d, pat(A));
      chk("R2", "bus_addr", b_addr, A);
      chk("R2", "bus_burst", b_burst, 1);
      chk("R5", "mru after fill start", buf_mru, 1);
      chk("R1", "no commit from empty buffer", aw_cnt, 0);
      bc = bus_cnt;
      fetch(A, 1, 0, src, d);
      chk("R4", "hit during fill", src, 1);
      chk("R4", "hit data", d, pat(A));
      fetch(32'h0000_1234, 1, 0, src, d);
      chk("R4", "late word waits then hits", src, 1);
      chk("R4", "late word data", d, pat(32'h0000_1234));
      chk("R4", "no extra bus request", bus_cnt, bc);
      for (int k = 0; k < 4; k++) begin
         logic [31:0] a2;
         a2 = {A[31:4], 2'(k), 2'b00};
         fetch(a2, 1, 0, src, d);
         chk("R2", "offset hit src", src, 1);
         chk("R2", "offset data", d, pat(a2));
      end

      // ---- array hits and recency ----
      fetch(32'h0000_5550, 1, 1, src, d);
      chk("R11", "array hit src", src, 2);
      chk("R6", "mru kept on other index", buf_mru, 1);
      fetch(A + 32'h400, 1, 1, src, d);
      chk("R11", "array hit same index", src, 2);
      chk("R6", "mru cleared on same index", buf_mru, 0);

      // ---- commit at next miss ----
      B = 32'h0000_2000;
      ac = aw_cnt;
      fetch(B, 1, 0, src, d);
      chk("R7", "commit count", aw_cnt, ac + 1);
      chk("R7", "aw_index", aw_idx_s, A[9:4]);
      chk("R7", "aw_tag", aw_tag_s, A[31:10]);
      check_line("R7", A);
      chk("R5", "mru after new fill", buf_mru, 1);

      // single misses: one commit of B, then none
      cfg_burst_en = 1'b0;
      fetch(32'h0000_3010, 1, 0, src, d);
      chk("R10", "single transfer", b_burst, 0);
      chk("R7", "commit of complete line", aw_cnt, ac + 2);
      chk("R7", "aw_index second", aw_idx_s, B[9:4]);
      check_line("R7", B);
      fetch(32'h0000_3020, 1, 0, src, d);
      chk("R7", "no repeated commit", aw_cnt, ac + 2);
      fetch(B + 4, 1, 0, src, d);
      chk("R7", "buffer still hits after commit", src, 1);
      chk("R7", "buffer data after commit", d, pat(B + 4));
      cfg_burst_en = 1'b1;

      // ---- noncacheable: array hit ignored, staged, never committed ----
      fetch(32'h0000_7770, 0, 1, src, d);
      chk("R11", "arr_hit ignored for noncacheable", src, 0);
      chk("R8", "noncacheable burst", b_burst, 1);
      ac = aw_cnt;
      fetch(32'h0000_7774, 0, 0, src, d);
      chk("R8", "noncacheable buffer hit", src, 1);
      fetch(32'h0000_8000, 1, 0, src, d);
      chk("R8", "noncacheable never committed", aw_cnt, ac);

      // ---- sweep every mode combination ----
      for (int m = 0; m < 16; m++) begin
         logic ce, be, bu, c, fill;
         logic [31:0] L, M;
         ce = m[3]; be = m[2]; bu = m[1]; c = m[0];
         fill = bu & ((ce & c) | be);
         do_reset();
         cfg_cache_en = ce; cfg_buf_en = be; cfg_burst_en = bu;
         L = 32'h0001_0004 | (32'(m) << 4);
         fetch(L, c, 0, src, d);
         chk("R9", "sweep miss src", src, 0);
         chk("R3", "sweep crit data", d, pat(L));
         chk("R9", "sweep burst select", b_burst, fill);
         chk("R5", "sweep mru", buf_mru, fill);
         bc = bus_cnt;
         fetch(L + 8, c, 0, src, d);
         chk("R9", "sweep second src", src, fill ? 1 : 0);
         chk("R9", "sweep second data", d, pat(L + 8));
         chk("R10", "sweep bus count", bus_cnt, fill ? bc : bc + 1);
         cfg_cache_en = 1'b1; cfg_buf_en = 1'b1; cfg_burst_en = 1'b1;
         ac = aw_cnt;
         M = 32'h0002_0000 | (32'(m) << 4);
         fetch(M, 1, 0, src, d);
         chk("R8", "sweep commit only for cacheable fill", aw_cnt, ac + ((fill & ce & c) ? 1 : 0));
         if (fill & ce & c) begin
            chk("R7", "sweep aw_index", aw_idx_s, L[9:4]);
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule